// File: doc/BRIEF.md
# Bypass Watchdog Timer Controller

This block guards a network bypass path with a software watchdog. Software reaches it through a small byte-wide register bus with two registers. The configuration register holds a 3-bit timeout code and shows a read-only expired flag. The mode register selects timer mode or force mode. While timer mode is active, a countdown runs on an external one-second tick. Software must keep restarting it by accessing the configuration register. If the countdown runs out, the expired flag latches and every enabled segment relay receives a close command.

A timeout code of zero means immediate expiry. A nonzero code c selects a timeout of 2^(c-1) ticks, so the range runs from 1 to 64 seconds. Any read or write of the configuration register restarts the countdown. Switching into timer mode also restarts it. Leaving timer mode clears the expired state and releases the relays. Clock division and the relay drivers sit outside the block.

Top module: `bypass_wdt`

## Requirements
- R1: After reset the block is in force mode with timeout code 111 and the expired flag clear. The configuration register reads 0x07, the mode register reads 0x00, and relay_close is all zero.
- R2: Register layout. At reg_addr 0 (configuration), bits 2:0 hold the read/write timeout code, bits 6:3 read as zero and ignore writes, and bit 7 is the read-only expired flag. At reg_addr 1 (mode), bit 0 set means timer mode and bit 0 clear means force mode; bits 7:1 read as zero and ignore writes.
- R3: In timer mode with code c from 1 to 7, the expired flag stays clear through 2^(c-1)-1 ticks after the last restart. It sets on the clock edge that samples tick number 2^(c-1).
- R4: A read or a write at reg_addr 0 restarts the countdown from the selected code; for a write, that is the code just written. When an access and a tick arrive in the same cycle, the restart wins.
- R5: A write that changes the mode bit from 0 to 1 restarts the countdown from the stored code.
- R6: In timer mode, a write of code 000 sets the expired flag on the next clock edge. Entering timer mode with code 000 stored does the same.
- R7: Once set, the expired flag stays set through further ticks and configuration accesses for as long as timer mode is kept.
- R8: A write that clears the mode bit clears the expired flag and deasserts relay_close on the next clock edge.
- R9: relay_close[i] is a registered copy of (expired and seg_en[i]). It follows a change of seg_en one clock later.
- R10: In force mode, ticks never set the expired flag and relay_close stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | One-cycle pulse once per second |
| reg_addr | input | 1 | Register select: 0 configuration, 1 mode |
| reg_rd | input | 1 | Read strobe (restarts the countdown at address 0) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| seg_en | input | NSEG | Segment relay enables |
| relay_close | output | NSEG | Close command per segment relay |

## Verification
The assertions assume that a read strobe and a write strobe are never raised in the same cycle. They also assume that sec_tick is a single-cycle pulse, and that seg_en changes only between clock edges. The bench meets these assumptions by driving every input on the falling clock edge. It raises one strobe at a time for exactly one cycle, and it issues each tick as a one-cycle pulse separated by an idle cycle. Register contents are observed without a read strobe by setting reg_addr alone, so that an observation never restarts the countdown.

// File: rtl/bypass_wdt_pkg.sv
package bypass_wdt_pkg;
  localparam int DATA_W = 8;
  localparam int CODE_W = 3;
  // Widest timeout is 2**(2**CODE_W - 2); this many bits hold it.
  localparam int CNT_W  = (1 << CODE_W) - 1;
  localparam int FLAG_BIT = DATA_W - 1;

  localparam logic [CODE_W-1:0] CODE_RST = '1;

  typedef enum logic {
    ADDR_CFG  = 1'b0,
    ADDR_MODE = 1'b1
  } reg_addr_e;

  // Code 0 loads zero (immediate expiry), code c loads 2**(c-1).
  function automatic logic [CNT_W-1:0] code_to_count(input logic [CODE_W-1:0] c);
    logic [CNT_W-1:0] v;
    v = '0;
    if (c != '0) v = CNT_W'(1) << (c - CODE_W'(1));
    return v;
  endfunction
endpackage

// File: rtl/bypass_wdt_rst_sync.sv
module bypass_wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bypass_wdt_regs.sv
module bypass_wdt_regs
  import bypass_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              expired,
  output logic [CODE_W-1:0] code_d,
  output logic              mode_q,
  output logic              mode_d,
  output logic              cfg_acc,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [CODE_W-1:0] code_q;
  logic              code_en;
  logic              mode_en;
  logic              sel_cfg;

  assign sel_cfg = (reg_addr == ADDR_CFG);

  always_comb begin
    code_en = reg_wr && sel_cfg;
    mode_en = reg_wr && !sel_cfg;
    code_d  = code_q;
    mode_d  = mode_q;
    if (code_en) code_d = reg_wdata[CODE_W-1:0];
    if (mode_en) mode_d = reg_wdata[0];
    cfg_acc = (reg_rd || reg_wr) && sel_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_RST;
      mode_q <= 1'b0;
    end else begin
      if (code_en) code_q <= code_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_cfg) begin
      reg_rdata[CODE_W-1:0] = code_q;
      reg_rdata[FLAG_BIT]   = expired;
    end else begin
      reg_rdata[0] = mode_q;
    end
  end
endmodule

// File: rtl/bypass_wdt_timer.sv
module bypass_wdt_timer
  import bypass_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode_q,
  input  logic              mode_d,
  input  logic              cfg_acc,
  input  logic [CODE_W-1:0] code_d,
  output logic              expired_q,
  output logic              expired_d
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] load_val;
  logic             load;
  logic             run;
  logic             step;
  logic             cnt_en;

  always_comb begin
    load     = cfg_acc || (mode_d && !mode_q);
    load_val = code_to_count(code_d);
    run      = mode_q && mode_d && !expired_q;
    step     = run && tick && (cnt_q != '0);
    cnt_en   = load || step;
    cnt_d    = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q - CNT_W'(1);
  end

  always_comb begin
    if (!mode_d)        expired_d = 1'b0;
    else if (expired_q) expired_d = 1'b1;
    else if (load)      expired_d = (load_val == '0);
    else                expired_d = step && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      expired_q <= expired_d;
    end
  end
endmodule

// File: rtl/bypass_wdt_relay.sv
module bypass_wdt_relay #(
  parameter int NSEG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            expired_d,
  input  logic [NSEG-1:0] seg_en,
  output logic [NSEG-1:0] relay_close
);
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic close_d;
    assign close_d = expired_d && seg_en[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) relay_close[i] <= 1'b0;
      else        relay_close[i] <= close_d;
    end
  end
endmodule

// File: rtl/bypass_wdt.sv
module bypass_wdt
  import bypass_wdt_pkg::*;
#(
  parameter int NSEG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSEG-1:0]   seg_en,
  output logic [NSEG-1:0]   relay_close
);
  logic              rst_sync_n;
  logic [CODE_W-1:0] code_d;
  logic              mode_q;
  logic              mode_d;
  logic              cfg_acc;
  logic              expired_q;
  logic              expired_d;

  bypass_wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bypass_wdt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .expired   (expired_q),
    .code_d    (code_d),
    .mode_q    (mode_q),
    .mode_d    (mode_d),
    .cfg_acc   (cfg_acc),
    .reg_rdata (reg_rdata)
  );

  bypass_wdt_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (sec_tick),
    .mode_q    (mode_q),
    .mode_d    (mode_d),
    .cfg_acc   (cfg_acc),
    .code_d    (code_d),
    .expired_q (expired_q),
    .expired_d (expired_d)
  );

  bypass_wdt_relay #(.NSEG(NSEG)) u_relay (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .expired_d   (expired_d),
    .seg_en      (seg_en),
    .relay_close (relay_close)
  );
endmodule

// File: rtl/bypass_wdt_chk.sv
module bypass_wdt_chk #(
  parameter int NSEG = 2
) (
  input logic            clk,
  input logic            rst_i,
  input logic            reg_addr,
  input logic            reg_wr,
  input logic [7:0]      reg_wdata,
  input logic [7:0]      reg_rdata,
  input logic [NSEG-1:0] seg_en,
  input logic [NSEG-1:0] relay_close,
  input logic            mode,
  input logic            expired
);
  assert_cfg_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_addr == 1'b0) |-> (reg_rdata[6:3] == 4'b0000));

  assert_mode_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_addr == 1'b1) |-> (reg_rdata[7:1] == 7'b0));

  assert_zero_code_expires_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (mode && reg_wr && reg_addr == 1'b0 && reg_wdata[2:0] == 3'b000) |=> expired);

  assert_expired_latched_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (expired && mode && !(reg_wr && reg_addr == 1'b1 && !reg_wdata[0])) |=> expired);

  assert_leave_clears_R8: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(mode) |-> (!expired && relay_close == '0));

  assert_relay_follows_R9: assert property (@(posedge clk) disable iff (!rst_i)
    1'b1 |=> (relay_close == ($past(seg_en) & {NSEG{expired}})));

  assert_force_no_expiry_R10: assert property (@(posedge clk) disable iff (!rst_i)
    !mode |-> !expired);
endmodule

bind bypass_wdt bypass_wdt_chk #(.NSEG(NSEG)) u_chk (
  .clk         (clk),
  .rst_i       (rst_sync_n),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .seg_en      (seg_en),
  .relay_close (relay_close),
  .mode        (mode_q),
  .expired     (expired_q)
);

// File: tb/tb_bypass_wdt.sv
`timescale 1ns/1ps
module tb_bypass_wdt;
  localparam int NSEG = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            sec_tick;
  logic            reg_addr;
  logic            reg_rd;
  logic            reg_wr;
  logic [7:0]      reg_wdata;
  logic [7:0]      reg_rdata;
  logic [NSEG-1:0] seg_en;
  logic [NSEG-1:0] relay_close;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bypass_wdt #(.NSEG(NSEG)) dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .seg_en(seg_en), .relay_close(relay_close)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic a);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  // Expired flag and relay state against the expected flag.
  task automatic expect_state(input string req, input logic [2:0] code, input logic exp_flag);
    logic [7:0] d;
    peek(1'b0, d);
    check(req, d, {exp_flag, 4'b0000, code});
    check(req, relay_close, exp_flag ? seg_en : '0);
  endtask

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; sec_tick = 1'b0; reg_addr = 1'b0; reg_rd = 1'b0;
    reg_wr = 1'b0; reg_wdata = '0; seg_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    peek(1'b0, d); check("R1 cfg", d, 8'h07);
    peek(1'b1, d); check("R1 mode", d, 8'h00);
    check("R1 relay", relay_close, 0);

    // R2 unused bits and read-only flag
    bus_wr(1'b0, 8'hFA); peek(1'b0, d); check("R2 cfg unused", d, 8'h02);
    bus_wr(1'b1, 8'hFE); peek(1'b1, d); check("R2 mode unused", d, 8'h00);
    bus_wr(1'b0, 8'h80); peek(1'b0, d); check("R2 flag read-only", d, 8'h00);

    // R10 force mode ignores ticks even with code 000 stored
    seg_en = 2'b11;
    ticks(5);
    expect_state("R10 force", 3'd0, 1'b0);

    // R6 entering timer mode with code 000
    bus_wr(1'b1, 8'h01);
    peek(1'b1, d); check("R2 mode set", d, 8'h01);
    expect_state("R6 enter zero", 3'd0, 1'b1);

    // R7 latched through ticks and accesses
    ticks(3); bus_rd(1'b0);
    expect_state("R7 after ticks/read", 3'd0, 1'b1);
    bus_wr(1'b0, 8'h05);
    expect_state("R7 after write", 3'd5, 1'b1);

    // R9 relay follows seg_en one clock later
    @(negedge clk); seg_en = 2'b01; #1;
    check("R9 before edge", relay_close, 2'b11);
    @(negedge clk);
    check("R9 after edge", relay_close, 2'b01);

    // R8 leaving timer mode
    bus_wr(1'b1, 8'h00);
    expect_state("R8 leave", 3'd5, 1'b0);
    check("R8 relay", relay_close, 0);

    // R3 sweep of every nonzero code, entering via R5 restart
    for (int c = 1; c <= 7; c++) begin
      int t;
      t = 1 << (c - 1);
      seg_en = NSEG'(c);
      bus_wr(1'b0, 8'(c));
      bus_wr(1'b1, 8'h01);
      ticks(t - 1);
      expect_state($sformatf("R3 code %0d early", c), 3'(c), 1'b0);
      ticks(1);
      expect_state($sformatf("R3 code %0d expiry", c), 3'(c), 1'b1);
      bus_wr(1'b1, 8'h00);
    end

    seg_en = 2'b10;
    // R4 read restart
    bus_wr(1'b0, 8'h03); bus_wr(1'b1, 8'h01);
    ticks(3); bus_rd(1'b0); ticks(3);
    expect_state("R4 read restart early", 3'd3, 1'b0);
    ticks(1);
    expect_state("R4 read restart expiry", 3'd3, 1'b1);
    bus_wr(1'b1, 8'h00);

    // R4 write restart with the new code
    bus_wr(1'b0, 8'h02); bus_wr(1'b1, 8'h01);
    ticks(1); bus_wr(1'b0, 8'h03); ticks(3);
    expect_state("R4 write restart early", 3'd3, 1'b0);
    ticks(1);
    expect_state("R4 write restart expiry", 3'd3, 1'b1);
    bus_wr(1'b1, 8'h00);

    // R4 access wins over coincident tick
    bus_wr(1'b0, 8'h01); bus_wr(1'b1, 8'h01);
    @(negedge clk); reg_addr = 1'b0; reg_rd = 1'b1; sec_tick = 1'b1;
    @(negedge clk); reg_rd = 1'b0; sec_tick = 1'b0;
    expect_state("R4 coincident", 3'd1, 1'b0);
    ticks(1);
    expect_state("R4 coincident expiry", 3'd1, 1'b1);
    bus_wr(1'b1, 8'h00);

    // R5 re-entering timer mode reloads a partly used count
    bus_wr(1'b0, 8'h03); bus_wr(1'b1, 8'h01);
    ticks(2); bus_wr(1'b1, 8'h00); bus_wr(1'b1, 8'h01);
    ticks(3);
    expect_state("R5 reload early", 3'd3, 1'b0);
    ticks(1);
    expect_state("R5 reload expiry", 3'd3, 1'b1);
    bus_wr(1'b1, 8'h00);

    // R6 write of 000 while running
    seg_en = 2'b11;
    bus_wr(1'b0, 8'h07); bus_wr(1'b1, 8'h01);
    ticks(2);
    bus_wr(1'b0, 8'h00);
    expect_state("R6 write zero", 3'd0, 1'b1);
    bus_wr(1'b1, 8'h00);

    // R10 force mode with shortest code
    bus_wr(1'b0, 8'h01);
    ticks(10);
    expect_state("R10 force code 1", 3'd1, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule